// File: doc/BRIEF.md
# Register Update Window with In-Order Retirement

This block is a ring of instruction slots that tracks every instruction from the moment it is decoded until its result is written to the architectural register file. The same ring serves two jobs. It chooses which waiting instruction goes to an execution unit next, in any order, as soon as its operands exist. It also retires finished instructions strictly in program order from the oldest slot. Decode claims the slot at the tail. Execution units return a result, an exception flag and a branch outcome by slot tag. Retirement presents the oldest finished slot's destination register and value for the register-file write.

Speculation is contained inside the ring. An instruction behind a branch that has not resolved cannot retire, because retirement only ever looks at the oldest slot. A branch reported as mispredicted discards every younger slot in one cycle and pulses a redirect with the branch tag so that fetch can restart. A fault reported by an execution unit is only stored in the slot. It is raised at the retire port when that slot becomes the oldest, and the ring is then emptied.

Operand readiness works on producer tags. Decode names, for each of two sources, whether it waits on an in-flight producer and that producer's slot tag. A result return with tag t marks ready every waiting source whose producer tag is t.

Top module: `reg_update_window`

## Requirements
- R1: After reset the ring is empty. `dec_ready` is 1 and `iss_valid`, `cmt_valid`, `exc_valid` and `redirect_valid` are 0.
- R2: An instruction accepted on the decode port (`dec_valid` and `dec_ready` both 1) takes the tag shown on `dec_tag`. Successive accepted instructions take consecutive tags, modulo DEPTH.
- R3: When DEPTH slots are occupied, `dec_ready` is 0 and a `dec_valid` pulse is ignored: no slot is claimed and the oldest slot's tag is unchanged.
- R4: At most one instruction issues per cycle. `iss_tag` is the oldest slot, counted from the retire end, that is occupied, not yet issued and has both sources ready. Each slot issues exactly once.
- R5: A source that waits on a producer tag becomes ready in the cycle after a result return with that tag. A return in the same cycle as the consumer's decode also counts. A consumer does not issue before that.
- R6: A result return (`wb_valid`, `wb_tag`) stores `wb_data` in the slot and marks it complete. The stored value appears on `cmt_data` when that slot retires.
- R7: Retirement takes only the oldest slot, once it is complete, at most one per cycle. `cmt_tag`, `cmt_dest` and `cmt_data` describe that slot.
- R8: While an older branch slot has not returned a result, no younger slot retires, even if the younger slot is complete.
- R9: A result return with `wb_mispredict` 1 for a slot decoded with `dec_is_branch` 1 pulses `redirect_valid` with `redirect_tag` equal to the branch tag in that cycle. It holds `dec_ready` at 0 and prevents issue of any slot younger than the branch. From the next cycle those younger slots never issue or retire, and the next accepted decode takes tag branch+1.
- R10: A result return with `wb_exc` 1 does not raise `exc_valid` by itself. When that slot is oldest and complete, `exc_valid` is 1 with `exc_tag` equal to its tag and `cmt_valid` 0. In the next cycle the ring is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_dest | input | REG_W | Destination architectural register |
| dec_src0_wait | input | 1 | Source 0 depends on an in-flight producer |
| dec_src0_tag | input | TAG_W | Producer tag of source 0 |
| dec_src1_wait | input | 1 | Source 1 depends on an in-flight producer |
| dec_src1_tag | input | TAG_W | Producer tag of source 1 |
| dec_is_branch | input | 1 | Instruction is a conditional branch |
| dec_ready | output | 1 | Ring can accept an instruction this cycle |
| dec_tag | output | TAG_W | Tag given to the instruction being decoded |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| wb_valid | input | 1 | Execution unit returns a result |
| wb_tag | input | TAG_W | Tag of the returning instruction |
| wb_data | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispredict | input | 1 | Branch resolved against its prediction |
| redirect_valid | output | 1 | Mispredict squash happens this cycle |
| redirect_tag | output | TAG_W | Tag of the mispredicted branch |
| cmt_valid | output | 1 | Oldest instruction retires to the register file |
| cmt_tag | output | TAG_W | Tag of the retiring instruction |
| cmt_dest | output | REG_W | Destination register of the retiring instruction |
| cmt_data | output | DATA_W | Value written to the register file |
| exc_valid | output | 1 | Deferred exception is delivered now |
| exc_tag | output | TAG_W | Tag of the faulting instruction |

## Verification
The main function is tried with short dependence chains, in which a consumer must wait for its producer's result and then issue in the following cycle. This separates correct wakeup timing from a design that issues too early or misses the broadcast. A branch left unresolved behind a finished younger instruction separates strict head-only retirement from retiring any finished slot. A full ring with a further decode request tells a true stall apart from a tail that wraps over live slots. Long random mixes of decodes with random producer tags, out-of-order result returns, mispredicts and faults are compared cycle by cycle with a bench model. These mixes separate oldest-first selection from plain lowest-index selection once the ring has wrapped, and they exercise squash and fault delivery at arbitrary ring positions.

// File: rtl/rw_pkg.sv
package rw_pkg;

  // Per-slot status flags, one bundle per ring position.
  typedef struct packed {
    logic live;     // slot holds an in-flight instruction
    logic sent;     // already handed to an execution unit
    logic finished; // result has returned
    logic fault;    // result came back with an exception
    logic is_br;    // instruction is a conditional branch
  } slot_flags_t;

  // Age of a ring position measured from the oldest slot (0 = oldest).
  // Ring size is a power of two.
  function automatic int unsigned age_of(int unsigned oldest, int unsigned pos,
                                         int unsigned ring);
    return (pos + ring - oldest) % ring;
  endfunction

endpackage

// File: rtl/rw_slot.sv
module rw_slot
  import rw_pkg::*;
#(
  parameter int TAG_W   = 4,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int SLOT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim_i,
  input  logic              kill_i,
  input  logic              retire_i,
  input  logic              send_i,
  input  logic [REG_W-1:0]  cl_dest_i,
  input  logic              cl_is_br_i,
  input  logic [TAG_W-1:0]  cl_prod0_i,
  input  logic [TAG_W-1:0]  cl_prod1_i,
  input  logic              cl_rdy0_i,
  input  logic              cl_rdy1_i,
  input  logic              res_ok_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              res_fault_i,
  output slot_flags_t       flags_o,
  output logic              ops_ready_o,
  output logic [REG_W-1:0]  dest_o,
  output logic [DATA_W-1:0] value_o
);

  localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(SLOT_ID);

  slot_flags_t       flags_q;
  logic              rdy0_q, rdy1_q;
  logic [TAG_W-1:0]  prod0_q, prod1_q;
  logic [REG_W-1:0]  dest_q;
  logic [DATA_W-1:0] value_q;

  // Named internal events for the assertions.
  logic res_hit, wake0, wake1;
  assign res_hit = res_ok_i && (res_tag_i == MY_TAG);
  assign wake0   = res_ok_i && !rdy0_q && (prod0_q == res_tag_i);
  assign wake1   = res_ok_i && !rdy1_q && (prod1_q == res_tag_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      rdy0_q  <= 1'b0;
      rdy1_q  <= 1'b0;
      prod0_q <= '0;
      prod1_q <= '0;
      dest_q  <= '0;
      value_q <= '0;
    end else if (kill_i) begin
      flags_q.live <= 1'b0;
    end else if (claim_i) begin
      flags_q.live     <= 1'b1;
      flags_q.sent     <= 1'b0;
      flags_q.finished <= 1'b0;
      flags_q.fault    <= 1'b0;
      flags_q.is_br    <= cl_is_br_i;
      rdy0_q           <= cl_rdy0_i;
      rdy1_q           <= cl_rdy1_i;
      prod0_q          <= cl_prod0_i;
      prod1_q          <= cl_prod1_i;
      dest_q           <= cl_dest_i;
    end else begin
      if (retire_i) flags_q.live <= 1'b0;
      if (send_i)   flags_q.sent <= 1'b1;
      if (res_hit) begin
        flags_q.finished <= 1'b1;
        flags_q.fault    <= res_fault_i;
        value_q          <= res_data_i;
      end
      if (wake0) rdy0_q <= 1'b1;
      if (wake1) rdy1_q <= 1'b1;
    end
  end

  assign flags_o     = flags_q;
  assign ops_ready_o = rdy0_q && rdy1_q;
  assign dest_o      = dest_q;
  assign value_o     = value_q;

  // R4: a slot is only sent while live, unsent and with both operands ready
  p_send_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    send_i |-> (flags_q.live && !flags_q.sent && rdy0_q && rdy1_q));

  // R7: only a complete slot is retired
  p_retire_finished_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire_i |-> (flags_q.live && flags_q.finished));

  // R2: a slot is never claimed while it still holds an instruction
  p_claim_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> !flags_q.live);

  // R6: a result never lands on a slot that has not been sent
  p_result_after_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (flags_q.sent && !flags_q.finished));

endmodule

// File: rtl/rw_ptrs.sv
module rw_ptrs
  import rw_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim_i,
  input  logic             retire_i,
  input  logic             squash_i,
  input  logic [TAG_W-1:0] squash_tag_i,
  input  logic             flush_all_i,
  output logic [TAG_W-1:0] oldest_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);

  logic [TAG_W-1:0] oldest_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic [TAG_W-1:0] keep_age;

  // Age of the mispredicted branch: it and everything older survive.
  assign keep_age = TAG_W'(age_of(int'(oldest_q), int'(squash_tag_i), DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oldest_q <= '0;
      tail_q   <= '0;
      count_q  <= '0;
    end else if (flush_all_i) begin
      oldest_q <= oldest_q + TAG_W'(1);
      tail_q   <= oldest_q + TAG_W'(1);
      count_q  <= '0;
    end else begin
      oldest_q <= oldest_q + TAG_W'(retire_i);
      if (squash_i) begin
        tail_q  <= squash_tag_i + TAG_W'(1);
        count_q <= CNT_W'(keep_age) + CNT_W'(1) - CNT_W'(retire_i);
      end else begin
        tail_q  <= tail_q + TAG_W'(claim_i);
        count_q <= count_q + CNT_W'(claim_i) - CNT_W'(retire_i);
      end
    end
  end

  assign oldest_o = oldest_q;
  assign tail_o   = tail_q;
  assign count_o  = count_q;
  assign full_o   = (count_q == CNT_W'(DEPTH));

  // R3: never claim a slot in a full ring
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> !full_o);

  // R2: pointers meet exactly when the ring is empty or full
  p_ptr_meet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (oldest_q == tail_q) == ((count_q == '0) || (count_q == CNT_W'(DEPTH))));

  // R10: a delivered fault leaves an empty ring behind
  p_fault_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all_i |=> (count_q == '0));

endmodule

// File: rtl/rw_oldest_pick.sv
module rw_oldest_pick #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 4
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [TAG_W-1:0] oldest_i,
  output logic             found_o,
  output logic [TAG_W-1:0] sel_o
);

  // Scan from the oldest slot forward and take the first request.
  always_comb begin
    found_o = 1'b0;
    sel_o   = oldest_i;
    for (int k = 0; k < DEPTH; k++) begin
      if (!found_o && req_i[oldest_i + TAG_W'(k)]) begin
        found_o = 1'b1;
        sel_o   = oldest_i + TAG_W'(k);
      end
    end
  end

endmodule

// File: rtl/reg_update_window.sv
module reg_update_window
  import rw_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [REG_W-1:0]  dec_dest,
  input  logic              dec_src0_wait,
  input  logic [TAG_W-1:0]  dec_src0_tag,
  input  logic              dec_src1_wait,
  input  logic [TAG_W-1:0]  dec_src1_tag,
  input  logic              dec_is_branch,
  output logic              dec_ready,
  output logic [TAG_W-1:0]  dec_tag,
  output logic              iss_valid,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_exc,
  input  logic              wb_mispredict,
  output logic              redirect_valid,
  output logic [TAG_W-1:0]  redirect_tag,
  output logic              cmt_valid,
  output logic [TAG_W-1:0]  cmt_tag,
  output logic [REG_W-1:0]  cmt_dest,
  output logic [DATA_W-1:0] cmt_data,
  output logic              exc_valid,
  output logic [TAG_W-1:0]  exc_tag
);

  slot_flags_t       flags [DEPTH];
  logic [DEPTH-1:0]  ops_ready;
  logic [REG_W-1:0]  slot_dest  [DEPTH];
  logic [DATA_W-1:0] slot_value [DEPTH];

  logic [TAG_W-1:0] oldest, tail;
  logic [CNT_W-1:0] count;
  logic             full;

  // Named events shared by the slots, the pointers and the assertions.
  logic             res_ok, head_done, squash, claim;
  logic             rdy0_now, rdy1_now;
  logic [DEPTH-1:0] younger, pick_req;
  logic             pick_found;
  logic [TAG_W-1:0] pick_sel;

  assign res_ok    = wb_valid && flags[wb_tag].live && flags[wb_tag].sent &&
                     !flags[wb_tag].finished;
  assign head_done = flags[oldest].live && flags[oldest].finished;
  assign exc_valid = head_done && flags[oldest].fault;
  assign cmt_valid = head_done && !flags[oldest].fault;
  assign squash    = res_ok && wb_mispredict && flags[wb_tag].is_br && !exc_valid;

  assign dec_ready = !full && !squash && !exc_valid;
  assign dec_tag   = tail;
  assign claim     = dec_valid && dec_ready;

  // Source readiness at decode, including a result returning this cycle.
  assign rdy0_now = !dec_src0_wait || !flags[dec_src0_tag].live ||
                    flags[dec_src0_tag].finished || (res_ok && wb_tag == dec_src0_tag);
  assign rdy1_now = !dec_src1_wait || !flags[dec_src1_tag].live ||
                    flags[dec_src1_tag].finished || (res_ok && wb_tag == dec_src1_tag);

  rw_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim_i     (claim),
    .retire_i    (head_done),
    .squash_i    (squash),
    .squash_tag_i(wb_tag),
    .flush_all_i (exc_valid),
    .oldest_o    (oldest),
    .tail_o      (tail),
    .count_o     (count),
    .full_o      (full)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign younger[g]  = squash &&
                         (age_of(int'(oldest), g, DEPTH) > age_of(int'(oldest), int'(wb_tag), DEPTH));
    assign pick_req[g] = flags[g].live && !flags[g].sent && ops_ready[g] &&
                         !younger[g] && !exc_valid;

    rw_slot #(.TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W), .SLOT_ID(g)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim_i    (claim && (tail == TAG_W'(g))),
      .kill_i     (exc_valid || younger[g]),
      .retire_i   (head_done && (oldest == TAG_W'(g))),
      .send_i     (iss_valid && (iss_tag == TAG_W'(g))),
      .cl_dest_i  (dec_dest),
      .cl_is_br_i (dec_is_branch),
      .cl_prod0_i (dec_src0_tag),
      .cl_prod1_i (dec_src1_tag),
      .cl_rdy0_i  (rdy0_now),
      .cl_rdy1_i  (rdy1_now),
      .res_ok_i   (res_ok),
      .res_tag_i  (wb_tag),
      .res_data_i (wb_data),
      .res_fault_i(wb_exc),
      .flags_o    (flags[g]),
      .ops_ready_o(ops_ready[g]),
      .dest_o     (slot_dest[g]),
      .value_o    (slot_value[g])
    );
  end

  rw_oldest_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
    .req_i   (pick_req),
    .oldest_i(oldest),
    .found_o (pick_found),
    .sel_o   (pick_sel)
  );

  assign iss_valid      = pick_found;
  assign iss_tag        = pick_sel;
  assign redirect_valid = squash;
  assign redirect_tag   = wb_tag;
  assign cmt_tag        = oldest;
  assign cmt_dest       = slot_dest[oldest];
  assign cmt_data       = slot_value[oldest];
  assign exc_tag        = oldest;

  // R9: decode is refused in a squash cycle
  p_squash_blocks_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !dec_ready);

  // R10: fault delivery writes no register and issues nothing
  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!cmt_valid && !iss_valid));

  // R10: after a fault the ring is open and has nothing to retire
  p_fault_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (dec_ready && !cmt_valid && !exc_valid && !iss_valid));

  // R9: the slot picked for issue is never one being squashed
  p_no_issue_squashed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !younger[iss_tag]);

  // R7: retirement takes the oldest slot, which then moves on by one
  p_retire_advances_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |=> (cmt_tag == $past(cmt_tag) + TAG_W'(1)));

endmodule

// File: tb/test_reg_update_window.sv
module test_reg_update_window;

  localparam int D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dv = 1'b0, dw0 = 1'b0, dw1 = 1'b0, dbr = 1'b0;
  logic [4:0]  ddest = '0;
  logic [3:0]  dp0 = '0, dp1 = '0, wt = '0;
  logic        wv = 1'b0, wx = 1'b0, wm = 1'b0;
  logic [31:0] wd = '0;

  logic        dec_ready, iss_valid, redirect_valid, cmt_valid, exc_valid;
  logic [3:0]  dec_tag, iss_tag, redirect_tag, cmt_tag, exc_tag;
  logic [4:0]  cmt_dest;
  logic [31:0] cmt_data;

  int checks = 0;
  int fails  = 0;

  // Bench model of the ring.
  bit          mv[D], mi[D], md[D], mx[D], mb[D], mr0[D], mr1[D];
  int          mp0[D], mp1[D], mdest[D];
  logic [31:0] mdat[D];
  int          mh = 0, mt = 0, mc = 0;

  always #10 clk = ~clk;

  reg_update_window i_reg_update_window (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dv), .dec_dest(ddest),
    .dec_src0_wait(dw0), .dec_src0_tag(dp0),
    .dec_src1_wait(dw1), .dec_src1_tag(dp1),
    .dec_is_branch(dbr), .dec_ready(dec_ready), .dec_tag(dec_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag),
    .wb_valid(wv), .wb_tag(wt), .wb_data(wd), .wb_exc(wx), .wb_mispredict(wm),
    .redirect_valid(redirect_valid), .redirect_tag(redirect_tag),
    .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_dest(cmt_dest), .cmt_data(cmt_data),
    .exc_valid(exc_valid), .exc_tag(exc_tag)
  );

  function automatic int age(int pos, int head);
    return (pos - head + D) % D;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_dec(int dest, bit w0, int p0, bit w1, int p1, bit br);
    dv = 1'b1; ddest = 5'(dest); dw0 = w0; dp0 = 4'(p0); dw1 = w1; dp1 = 4'(p1); dbr = br;
  endtask

  task automatic set_wb(int tag, logic [31:0] data, bit exc, bit mis);
    wv = 1'b1; wt = 4'(tag); wd = data; wx = exc; wm = mis;
  endtask

  // One cycle: compare outputs against the model, advance the model, clock.
  task automatic step();
    bit cgo, ec, ex, wok, mis, full, drdy, alloc, r0, r1, fnd, kill;
    int sel, wtag, p0, p1;
    #1;
    wtag = int'(wt); p0 = int'(dp0); p1 = int'(dp1);
    cgo  = mv[mh] && md[mh];
    ec   = cgo && !mx[mh];
    ex   = cgo && mx[mh];
    wok  = wv && mv[wtag] && mi[wtag] && !md[wtag];
    mis  = wok && wm && mb[wtag] && !ex;
    full = (mc == D);
    drdy = !full && !mis && !ex;
    alloc = dv && drdy;
    fnd = 1'b0; sel = 0;
    for (int k = 0; k < D; k++) begin
      int j;
      j = (mh + k) % D;
      if (!fnd && !ex && mv[j] && !mi[j] && mr0[j] && mr1[j] &&
          !(mis && age(j, mh) > age(wtag, mh))) begin
        fnd = 1'b1; sel = j;
      end
    end
    chk(full ? "R3" : "R2", "dec_ready", dec_ready, drdy);
    if (drdy) chk("R2", "dec_tag", dec_tag, mt);
    chk("R4", "iss_valid", iss_valid, fnd);
    if (fnd) chk("R4", "iss_tag", iss_tag, sel);
    chk("R7", "cmt_valid", cmt_valid, ec);
    if (ec) begin
      chk("R7", "cmt_tag", cmt_tag, mh);
      chk("R7", "cmt_dest", cmt_dest, mdest[mh]);
      chk("R6", "cmt_data", cmt_data, mdat[mh]);
    end
    chk("R9", "redirect_valid", redirect_valid, mis);
    if (mis) chk("R9", "redirect_tag", redirect_tag, wtag);
    chk("R10", "exc_valid", exc_valid, ex);
    if (ex) chk("R10", "exc_tag", exc_tag, mh);

    r0 = !dw0 || !mv[p0] || md[p0] || (wok && wtag == p0);
    r1 = !dw1 || !mv[p1] || md[p1] || (wok && wtag == p1);
    if (ex) begin
      for (int i = 0; i < D; i++) mv[i] = 1'b0;
      mh = (mh + 1) % D; mt = mh; mc = 0;
    end else begin
      for (int i = 0; i < D; i++) begin
        kill = mis && (age(i, mh) > age(wtag, mh));
        if (kill) mv[i] = 1'b0;
        else if (alloc && i == mt) begin
          mv[i] = 1'b1; mi[i] = 1'b0; md[i] = 1'b0; mx[i] = 1'b0; mb[i] = dbr;
          mr0[i] = r0; mr1[i] = r1; mp0[i] = p0; mp1[i] = p1; mdest[i] = int'(ddest);
        end else begin
          if (cgo && i == mh) mv[i] = 1'b0;
          if (fnd && i == sel) mi[i] = 1'b1;
          if (wok && i == wtag) begin md[i] = 1'b1; mx[i] = wx; mdat[i] = wd; end
          if (wok && !mr0[i] && mp0[i] == wtag) mr0[i] = 1'b1;
          if (wok && !mr1[i] && mp1[i] == wtag) mr1[i] = 1'b1;
        end
      end
      if (mis) mc = age(wtag, mh) + 1 - int'(cgo);
      else     mc = mc + int'(alloc) - int'(cgo);
      mt = mis ? (wtag + 1) % D : (mt + int'(alloc)) % D;
      mh = (mh + int'(cgo)) % D;
    end
    @(posedge clk);
    #1;
    dv = 1'b0; dw0 = 1'b0; dw1 = 1'b0; dbr = 1'b0; wv = 1'b0; wx = 1'b0; wm = 1'b0;
    @(negedge clk);
  endtask

  // Constrained random stimulus drawn against the model state.
  task automatic rand_in(bit dec_on);
    int elig[D];
    int n;
    int t;
    n = 0;
    dv    = dec_on && ($urandom % 4 != 0);
    ddest = 5'($urandom);
    dbr   = ($urandom % 5 == 0);
    t = $urandom % D; dp0 = 4'(t); dw0 = mv[t] && ($urandom % 2 == 0);
    t = $urandom % D; dp1 = 4'(t); dw1 = mv[t] && ($urandom % 2 == 0);
    for (int i = 0; i < D; i++) if (mv[i] && mi[i] && !md[i]) begin elig[n] = i; n++; end
    if (n > 0 && ($urandom % 3 != 0)) begin
      t = elig[$urandom % n];
      set_wb(t, $urandom, ($urandom % 30 == 0), mb[t] && ($urandom % 3 == 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int b, e;
    void'($urandom(32'd24601));
    for (int i = 0; i < D; i++) begin
      mv[i] = 0; mi[i] = 0; md[i] = 0; mx[i] = 0; mb[i] = 0; mr0[i] = 0; mr1[i] = 0;
      mp0[i] = 0; mp1[i] = 0; mdest[i] = 0; mdat[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    chk("R1", "dec_ready after reset", dec_ready, 1);
    chk("R1", "iss_valid after reset", iss_valid, 0);
    chk("R1", "cmt_valid after reset", cmt_valid, 0);
    chk("R1", "exc_valid after reset", exc_valid, 0);
    chk("R1", "redirect_valid after reset", redirect_valid, 0);

    // R8: unresolved branch (tag 0) holds back a finished younger slot (tag 1)
    set_dec(1, 0, 0, 0, 0, 1); step();
    set_dec(2, 0, 0, 0, 0, 0); step();
    step();
    set_wb(1, 32'h0000_1111, 0, 0); step();
    repeat (2) begin
      #1 chk("R8", "cmt_valid behind open branch", cmt_valid, 0);
      step();
    end
    set_wb(0, 32'h0000_2222, 0, 0); step();
    #1 chk("R8", "branch retires once resolved", cmt_valid, 1);
    step(); step();

    // R5: consumer (tag 3) waits on producer (tag 2)
    set_dec(3, 0, 0, 0, 0, 0); step();
    set_dec(4, 1, 2, 0, 0, 0); step();
    #1 chk("R5", "consumer held before result", iss_valid, 0);
    step();
    set_wb(2, 32'h0000_3333, 0, 0);
    #1 chk("R5", "consumer held in result cycle", iss_valid, 0);
    step();
    #1 chk("R5", "consumer issues after wakeup", iss_valid, 1);
    chk("R5", "consumer tag", iss_tag, 3);
    step();
    set_wb(3, 32'h0000_4444, 0, 0); step();
    repeat (3) step();

    // R3: fill the ring, then a further decode is ignored
    for (int i = 0; i < D; i++) begin set_dec(i, 0, 0, 0, 0, 0); step(); end
    set_dec(31, 0, 0, 0, 0, 0);
    #1 chk("R3", "dec_ready when full", dec_ready, 0);
    step();
    for (int i = 0; i < 400 && mc != 0; i++) begin rand_in(0); step(); end
    chk("R3", "ring drained", mc, 0);

    // R9: mispredicted branch squashes three younger slots
    b = mt;
    set_dec(7, 0, 0, 0, 0, 1); step();
    for (int i = 0; i < 3; i++) begin set_dec(8 + i, 0, 0, 0, 0, 0); step(); end
    set_wb(b, 32'h0000_5555, 0, 1);
    #1 chk("R9", "redirect on mispredict", redirect_valid, 1);
    step();
    set_dec(12, 0, 0, 0, 0, 0);
    #1 chk("R9", "tag after squash", dec_tag, (b + 1) % D);
    step();
    for (int i = 0; i < 100 && mc != 0; i++) begin rand_in(0); step(); end

    // R10: fault on a younger slot is deferred until it is oldest
    e = mt;
    set_dec(13, 0, 0, 0, 0, 0); step();
    set_dec(14, 0, 0, 0, 0, 0); step();
    step();
    set_wb((e + 1) % D, 32'h0000_6666, 1, 0); step();
    #1 chk("R10", "fault not raised early", exc_valid, 0);
    step();
    set_wb(e, 32'h0000_7777, 0, 0); step();
    step();
    #1 chk("R10", "fault raised at head", exc_valid, 1);
    step();
    #1 chk("R10", "ring open after fault", dec_ready, 1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin rand_in(1); step(); end
    for (int i = 0; i < 500 && mc != 0; i++) begin rand_in(0); step(); end
    chk("R7", "final drain", mc, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule